// File: doc/BRIEF.md
# Multi-Mode Video Input Capture

This block sits behind a parallel video input of four bits per pixel and turns the incoming stream into write requests for a 320×240 frame store. Each sample becomes one write with a column, a row and the four data bits. Samples outside the visible 320×240 window produce no write. The store itself lives outside the block. Nothing is written while no video arrives, so the store keeps its last picture.

Five capture modes are supported:
- A legacy sync mode, in which rows are framed by the falling edge of HS.
- Two QVGA panel modes, one positioned by DE and one at a fixed offset.
- Two VGA panel modes, likewise one positioned by DE and one at a fixed offset. Only the upper-left 320×240 part of the 640×480 image is kept.

The mode is not programmed. A free-running window counter watches DE. At the end of every window the block chooses:
- DE-positioned capture if DE toggled often enough.
- Fixed-offset capture if DE rested low.
- The legacy sync mode if DE rested high.

The format input picks QVGA or VGA for the panel modes. A shutdown input blocks all writes.

Top module: `vid_capture`

## Requirements
- R1: All inputs are sampled on the falling edge of `vclk`. One pixel is taken per edge. After the falling edge on which a pixel is accepted, `we_o` is high and `pix_o` holds that edge's `pix_i` with its bit order kept: bit 3 red high, bit 2 red low, bit 1 green high, bit 0 green low.
- R2: At the end of each window of `WIN_LEN` edges, `mode_o` is set as follows:
  - More than `DE_MIN` (8) DE transitions in the window select DE-positioned capture: code 1 for QVGA or code 3 for VGA, chosen by `fmt_vga_i`.
  - Otherwise, DE sampled low at the window end selects fixed capture: code 2 for QVGA or code 4 for VGA.
  - Otherwise, DE high selects the legacy sync mode, code 0.
  - Exactly 8 transitions do not count as DE activity.
- R3: `mode_o` changes only at a window end. After a change, no write occurs until a new frame start has been seen under the new mode.
- R4: In legacy sync mode, a falling edge of HS starts a row. That row is row 0 if VS is high on that edge; otherwise the row number is one more than the previous row. The next 320 falling edges carry columns 0 to 319.
- R5: In the DE-positioned modes, the edge on which DE is first seen high carries column 0. Each further edge with DE high carries the next column.
- R6: In the fixed modes, counting the edge on which HS is first seen high as edge 1, column 0 is on edge 52 (QVGA) or edge 104 (VGA). The following edges carry consecutive columns.
- R7: In the panel modes, a falling edge of VS restarts the line count, and each rising edge of HS advances it. Row 0 is the line begun by the 7th (QVGA) or the 34th (VGA) rising edge of HS.
- R8: No write is made for a column above 319 or a row above 239. In the VGA modes this keeps exactly the upper-left quadrant.
- R9: While `shdn_i` is high, `we_o` stays low on the following edge.
- R10: After reset `we_o` is low and `mode_o` is 0. With no sync edges arriving, no write is made.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vclk | input | 1 | Video clock; capture on its falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| hs_i | input | 1 | Horizontal sync |
| vs_i | input | 1 | Vertical sync |
| de_i | input | 1 | Data enable |
| fmt_vga_i | input | 1 | 1 selects VGA, 0 QVGA, for the panel modes |
| shdn_i | input | 1 | Shutdown: blocks writes |
| pix_i | input | 4 | Pixel: {red hi, red lo, green hi, green lo} |
| we_o | output | 1 | Frame store write enable |
| x_o | output | 9 | Write column |
| y_o | output | 8 | Write row |
| pix_o | output | 4 | Write data |
| mode_o | output | 3 | Current capture mode code |

## Verification
A wrong column or line counter shows up as a skewed picture. The data driven into each pixel encodes its own column and row, so the first write after a wrong start offset carries data that disagrees with its address. The per-frame write count and the sums of the addresses also move.

A wrong mode decision shows on `mode_o` one window after the stimulus changes. The threshold test with exactly eight and then ten DE transitions sets the limit to the transition. A mode register that changes between window ends is caught by the spacing between the observed mode changes.

// File: rtl/vid_capture.sv
module vid_capture #(
  parameter int H_ACT     = 320,
  parameter int V_ACT     = 240,
  parameter int QVGA_HOFS = 52,
  parameter int VGA_HOFS  = 104,
  parameter int QVGA_VOFS = 7,
  parameter int VGA_VOFS  = 34,
  parameter int WIN_LEN   = 625000,
  parameter int DE_MIN    = 8,
  localparam int XW = $clog2(H_ACT),
  localparam int YW = $clog2(V_ACT),
  localparam int CW = $clog2(2*H_ACT + VGA_HOFS) + 1,
  localparam int LW = $clog2(2*V_ACT + VGA_VOFS) + 1,
  localparam int WW = $clog2(WIN_LEN),
  localparam int TW = $clog2(DE_MIN + 2)
)(
  input  logic          vclk,
  input  logic          rst_n,
  input  logic          hs_i,
  input  logic          vs_i,
  input  logic          de_i,
  input  logic          fmt_vga_i,
  input  logic          shdn_i,
  input  logic [3:0]    pix_i,
  output logic          we_o,
  output logic [XW-1:0] x_o,
  output logic [YW-1:0] y_o,
  output logic [3:0]    pix_o,
  output logic [2:0]    mode_o
);

  typedef enum logic [2:0] {
    M_SYNC = 3'd0, M_QDE = 3'd1, M_QFIX = 3'd2, M_VDE = 3'd3, M_VFIX = 3'd4
  } mode_t;

  mode_t          mode_q, mode_nx;
  logic           hs_q, vs_q, de_q;
  logic [WW-1:0]  wcnt;
  logic [TW-1:0]  tcnt;
  logic [CW-1:0]  cnt, col;
  logic [LW-1:0]  lcnt;
  logic           col_ok;

  function automatic logic [CW-1:0] inc_c(input logic [CW-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  function automatic logic [LW-1:0] inc_l(input logic [LW-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  wire hs_fall = hs_q & ~hs_i;
  wire hs_rise = ~hs_q & hs_i;
  wire vs_fall = vs_q & ~vs_i;
  wire de_rise = ~de_q & de_i;
  wire win_end = (wcnt == WW'(WIN_LEN - 1));

  wire vga     = (mode_q == M_VDE) || (mode_q == M_VFIX);
  wire sync_md = (mode_q == M_SYNC);
  wire de_md   = (mode_q == M_QDE) || (mode_q == M_VDE);

  always_comb begin
    if (tcnt > TW'(DE_MIN))  mode_nx = fmt_vga_i ? M_VDE : M_QDE;
    else if (de_i)           mode_nx = M_SYNC;
    else                     mode_nx = fmt_vga_i ? M_VFIX : M_QFIX;
  end

  wire mode_chg = win_end && (mode_nx != mode_q);

  wire [CW-1:0] hofs = vga ? CW'(VGA_HOFS - 2) : CW'(QVGA_HOFS - 2);
  wire [LW-1:0] vofs = sync_md ? '0 : (vga ? LW'(VGA_VOFS) : LW'(QVGA_VOFS));
  wire [LW-1:0] row    = lcnt - vofs;
  wire          row_ok = (lcnt >= vofs) && (row < LW'(V_ACT));

  always_comb begin
    if (sync_md) begin
      col    = cnt;
      col_ok = !hs_fall && (cnt < CW'(H_ACT));
    end else if (de_md) begin
      col    = de_rise ? '0 : cnt;
      col_ok = de_i && (col < CW'(H_ACT));
    end else begin
      col    = cnt - hofs;
      col_ok = !hs_rise && (cnt >= hofs) && (col < CW'(H_ACT));
    end
  end

  always_ff @(negedge vclk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= 1'b0; vs_q <= 1'b0; de_q <= 1'b0;
      wcnt <= '0; tcnt <= '0; mode_q <= M_SYNC;
      cnt <= '1; lcnt <= '1;
      we_o <= 1'b0; x_o <= '0; y_o <= '0; pix_o <= '0;
    end else begin
      hs_q <= hs_i; vs_q <= vs_i; de_q <= de_i;
      wcnt <= win_end ? '0 : wcnt + 1'b1;
      if (win_end)                                  tcnt <= '0;
      else if ((de_i != de_q) && tcnt <= TW'(DE_MIN)) tcnt <= tcnt + 1'b1;
      if (win_end) mode_q <= mode_nx;

      we_o  <= col_ok && row_ok && !shdn_i;
      x_o   <= col[XW-1:0];
      y_o   <= row[YW-1:0];
      pix_o <= pix_i;

      if (mode_chg)     cnt <= '1;
      else if (sync_md) cnt <= hs_fall ? '0 : inc_c(cnt);
      else if (de_md)   cnt <= de_rise ? CW'(1) : (de_i ? inc_c(cnt) : '1);
      else              cnt <= hs_rise ? '0 : inc_c(cnt);

      if (mode_chg)     lcnt <= '1;
      else if (sync_md) begin
        if (hs_fall)    lcnt <= vs_i ? '0 : inc_l(lcnt);
      end
      else if (vs_fall) lcnt <= '0;
      else if (hs_rise) lcnt <= inc_l(lcnt);
    end
  end

  assign mode_o = mode_q;

  AST_WR_IN_RANGE: assert property (@(negedge vclk) disable iff (!rst_n)
    we_o |-> ({1'b0, x_o} < (XW+1)'(H_ACT)) && ({1'b0, y_o} < (YW+1)'(V_ACT))); // R8
  AST_SHDN_BLOCKS: assert property (@(negedge vclk) disable iff (!rst_n)
    shdn_i |=> !we_o); // R9
  AST_MODE_AT_WINDOW: assert property (@(negedge vclk) disable iff (!rst_n)
    !$stable(mode_q) |-> $past(win_end)); // R3
  AST_CHG_FLUSH: assert property (@(negedge vclk) disable iff (!rst_n)
    mode_chg |=> ##1 !we_o); // R3
  AST_MODE_LEGAL: assert property (@(negedge vclk) disable iff (!rst_n)
    mode_q <= M_VFIX); // R2
  AST_X_STEP: assert property (@(negedge vclk) disable iff (!rst_n)
    (we_o && $past(we_o) && y_o == $past(y_o)) |-> x_o == $past(x_o) + 1'b1); // R5

endmodule

// File: tb/vid_capture_tb.sv
`timescale 1ns/1ps
module vid_capture_tb;
  localparam int H = 16, V = 8, WIN = 1024, LINE = 150;
  localparam int QHO = 52, VHO = 104, QVO = 7, VVO = 34;
  // vector: [15] shdn, [14:12] style, [11:9] expected mode, [8:0] expected writes
  localparam logic [15:0] VEC [7] = '{
    {1'b0, 3'd0, 3'd0, 9'd128},
    {1'b0, 3'd1, 3'd1, 9'd128},
    {1'b0, 3'd2, 3'd2, 9'd128},
    {1'b0, 3'd3, 3'd3, 9'd128},
    {1'b0, 3'd4, 3'd4, 9'd128},
    {1'b1, 3'd4, 3'd4, 9'd0},
    {1'b0, 3'd0, 3'd0, 9'd128}
  };

  logic vclk = 0, rst_n = 0, hs = 0, vs = 0, de = 0, fmt = 0, shdn = 0;
  logic [3:0] pix = 0;
  logic we; logic [3:0] xa; logic [2:0] ya; logic [3:0] pxo; logic [2:0] mode;

  vid_capture #(.H_ACT(H), .V_ACT(V), .QVGA_HOFS(QHO), .VGA_HOFS(VHO),
                .QVGA_VOFS(QVO), .VGA_VOFS(VVO), .WIN_LEN(WIN), .DE_MIN(8)) u_dut (
    .vclk(vclk), .rst_n(rst_n), .hs_i(hs), .vs_i(vs), .de_i(de),
    .fmt_vga_i(fmt), .shdn_i(shdn), .pix_i(pix),
    .we_o(we), .x_o(xa), .y_o(ya), .pix_o(pxo), .mode_o(mode));

  always #10 vclk = ~vclk;

  int n_run = 0, n_fail = 0, ncyc = 0;
  int wr_cnt = 0, bad_pix = 0, sum_x = 0, sum_y = 0, post_wr = 0;
  int first_chg = 0, last_chg = 0, chg_bad = 0;
  bit have_chg = 0, settle_chg = 0, done = 0;
  logic [2:0] mode_prev = 0;

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic observe();
    if (we) begin
      wr_cnt++; post_wr++;
      sum_x += int'(xa); sum_y += int'(ya);
      if (pxo != 4'(int'(xa) + int'(ya))) bad_pix++;
    end
    if (mode !== mode_prev) begin
      if (have_chg && ((ncyc - first_chg) % WIN) != 0) chg_bad++;
      if (!have_chg) begin have_chg = 1; first_chg = ncyc; end
      last_chg = ncyc; mode_prev = mode; settle_chg = 1; post_wr = 0;
    end
  endtask

  task automatic cyc(input logic h, input logic v, input logic d, input logic [3:0] p);
    @(posedge vclk);
    ncyc++;
    observe();
    hs = h; vs = v; de = d; pix = p;
  endtask

  task automatic run_line(input int st, input logic vsl, input int r);
    int nc;
    nc = (st >= 3) ? 2*H : H;
    for (int c = 0; c < LINE; c++) begin
      logic h, d; logic [3:0] p; int xi, ho;
      h = 0; d = 0; p = 0; xi = -1;
      if (st == 0) begin
        h = (c < 2); d = 1;
        if (c >= 3 && c < 3 + H) xi = c - 3;
      end else begin
        h = (c >= 2);
        if (st == 1 || st == 3) begin
          if (c >= 20 && c < 20 + nc) begin d = 1; xi = c - 20; end
        end else begin
          ho = (st == 2) ? QHO : VHO;
          if (c >= 1 + ho && c < 1 + ho + nc) xi = c - 1 - ho;
        end
      end
      if (xi >= 0 && r >= 0) p = 4'(xi + r);
      cyc(h, vsl, d, p);
    end
  endtask

  task automatic run_frame(input int st);
    int vo, nr, r;
    if (st == 0) begin
      for (int l = 0; l < V + 2; l++) run_line(0, l == 0, (l < V) ? l : -1);
    end else begin
      vo = (st <= 2) ? QVO : VVO;
      nr = (st >= 3) ? 2*V : V;
      for (int l = 0; l < vo - 1 + nr + 2; l++) begin
        r = l - (vo - 1);
        run_line(st, !(l < 2), (r >= 0 && r < nr) ? r : -1);
      end
    end
  endtask

  task automatic pulses(input int n);
    for (int k = 0; k < n; k++) begin
      repeat (5) cyc(0, 0, 0, 0);
      repeat (5) cyc(0, 0, 1, 0);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  function automatic string style_req(input int st);
    return (st == 0) ? "R4" : ((st == 1 || st == 3) ? "R5" : "R6");
  endfunction

  initial begin
    int st, b;
    repeat (3) @(posedge vclk);
    chk("R10 reset we", we == 0, we, 0);
    chk("R10 reset mode", mode == 0, mode, 0);
    rst_n = 1;

    for (int i = 0; i < 7; i++) begin
      st = int'(VEC[i][14:12]);
      fmt = (st >= 3); shdn = VEC[i][15]; settle_chg = 0;
      for (int l = 0; l < 15; l++) run_line(st, (st == 0) ? 1'b0 : 1'b1, -1);
      chk("R2 mode after settle", mode == VEC[i][11:9], mode, int'(VEC[i][11:9]));
      if (settle_chg) chk("R3 no write after mode change", post_wr == 0, post_wr, 0);
      wr_cnt = 0; sum_x = 0; sum_y = 0; bad_pix = 0;
      run_frame(st);
      if (VEC[i][15]) chk("R9 shutdown writes", wr_cnt == 0, wr_cnt, 0);
      else begin
        chk({style_req(st), " R8 write count"}, wr_cnt == int'(VEC[i][8:0]), wr_cnt, int'(VEC[i][8:0]));
        chk("R1 pixel data vs address", bad_pix == 0, bad_pix, 0);
        chk({style_req(st), " column sum"}, sum_x == V*H*(H-1)/2, sum_x, V*H*(H-1)/2);
        chk((st == 0) ? "R4 row sum" : "R7 row sum", sum_y == H*V*(V-1)/2, sum_y, H*V*(V-1)/2);
      end
    end

    wr_cnt = 0;
    repeat (300) cyc(0, 0, 1, 0);
    chk("R10 no write without video", wr_cnt == 0, wr_cnt, 0);

    b = last_chg;
    while (b <= ncyc) b += WIN;
    while (ncyc < b + 100) cyc(0, 0, 1, 0);
    pulses(4);
    while (ncyc < b + WIN + 10) cyc(0, 0, 1, 0);
    chk("R2 eight transitions stay legacy", mode == 0, mode, 0);
    while (ncyc < b + WIN + 100) cyc(0, 0, 1, 0);
    pulses(5);
    while (ncyc < b + 2*WIN + 10) cyc(0, 0, 1, 0);
    chk("R2 ten transitions select DE QVGA", mode == 1, mode, 1);
    chk("R3 mode changes on window ends", chg_bad == 0, chg_bad, 0);

    done = 1;
    summary();
  end

  initial begin
    #4_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      summary();
    end
  end
endmodule